// File: doc/BRIEF.md
# Receive Descriptor List Walker

This block steps through a list of receive descriptors held in memory on behalf of a receive DMA engine. It fetches one descriptor at a time through a simple read port, decodes the control word, and hands the data mover up to two buffer requests, each with an address and a byte count. Buffer 1 always comes before buffer 2. Once the last buffer of a descriptor is released, the walker works out where the next descriptor sits and fetches it while `run` is high.

The next descriptor can be in one of three places. It is the entry 16 bytes further on in a ring, the list base address when the descriptor closes the ring, or an explicit pointer when the descriptor is chained. A frame that does not fit in the current descriptor's buffers carries on in the next descriptor. When a frame ends, the walker raises the receive-complete strobe unless the descriptor asks for that strobe to be suppressed. A buffer size that breaks the 32-bit alignment rule stops the walker in an error state until reset.

A descriptor is four 32-bit words: status, control, buffer-1 address, and buffer-2 address or next pointer. The status word is outside this block's concern, so the read port returns only the last three.

Top module: `rx_desc_walker`

## Requirements
- R1: A synchronous active-high reset puts the walker in idle with `rd_req` and `buf_valid` low, `size_err` low and `rd_addr` equal to `base_addr`, so the first fetch after reset goes to the base address.
- R2: `rd_req` stays high and `rd_addr` stays stable until the cycle in which `rd_valid` is high; `rd_addr` is the current descriptor's address.
- R3: A descriptor that is not chained issues buffer 1 first (`buf_sel`=0, address from `rd_buf1`, size from control bits 12:0) and then buffer 2 (`buf_sel`=1, address from `rd_buf2`, size from control bits 28:16). Each request is held until `buf_done` or `frame_end` releases it. Releasing the last buffer moves the walker on to the next descriptor.
- R4: When the buffer-1 size is zero, no buffer-1 request is issued. The walker goes straight to buffer 2, or to the next descriptor when the descriptor is chained.
- R5: A descriptor that is not chained and has both sizes zero issues no buffer request, and the walker advances to the next descriptor.
- R6: When neither control bit 15 nor bit 14 is set, the next descriptor address is the current address plus 16.
- R7: When control bit 14 is set and bit 15 is clear, the next descriptor address is `rd_buf2`. No buffer-2 request is issued, and the buffer-2 size is ignored, even if it is not a multiple of 4.
- R8: When control bit 15 is set, the next descriptor address is `base_addr`. Bit 15 overrides bit 14: with both set, buffer 2 is a data buffer and the walker then returns to the base.
- R9: `rx_done` is high in the cycle in which `frame_end` is high while a buffer request is active, unless control bit 31 of that descriptor is set, in which case `rx_done` stays low.
- R10: A buffer size that will be used (buffer 1 when nonzero, and buffer 2 when not chained) with bits 1:0 not zero sets `size_err` high from the next cycle. In that case no buffer is issued and no further fetch takes place until reset.
- R11: Control bits 30:29 and 13 have no effect on the requests or the next address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| base_addr | input | 32 | Descriptor list base address |
| run | input | 1 | Allows descriptor fetches |
| rd_req | output | 1 | Descriptor fetch request |
| rd_addr | output | 32 | Address of the descriptor being fetched |
| rd_valid | input | 1 | Descriptor words are valid this cycle |
| rd_ctrl | input | 32 | Control word |
| rd_buf1 | input | 32 | Buffer-1 address word |
| rd_buf2 | input | 32 | Buffer-2 address or next-descriptor pointer |
| buf_valid | output | 1 | Buffer request active |
| buf_sel | output | 1 | 0 = buffer 1, 1 = buffer 2 |
| buf_addr | output | 32 | Buffer start address |
| buf_size | output | 13 | Buffer size in bytes |
| buf_done | input | 1 | Current buffer filled, frame continues |
| frame_end | input | 1 | Frame ended in current buffer |
| rx_done | output | 1 | Receive-complete status strobe |
| size_err | output | 1 | Misaligned buffer size, walker halted |

## Verification
The assertions take for granted that `base_addr` is held steady while the walker runs. They also assume that `rd_valid` is driven only while `rd_req` is high, and that `buf_done` and `frame_end` arrive only while `buf_valid` is high, one pulse per buffer. The stimulus holds the base at one value and answers each fetch with a single one-cycle `rd_valid` pulse, sometimes after a delay. It releases each buffer with exactly one pulse taken in the cycle after the request appears.

// File: rtl/rx_desc_walker.sv
module rx_desc_walker #(
  parameter int AW  = 32,
  parameter int SZW = 13
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [AW-1:0]  base_addr,
  input  logic           run,
  output logic           rd_req,
  output logic [AW-1:0]  rd_addr,
  input  logic           rd_valid,
  input  logic [31:0]    rd_ctrl,
  input  logic [AW-1:0]  rd_buf1,
  input  logic [AW-1:0]  rd_buf2,
  output logic           buf_valid,
  output logic           buf_sel,
  output logic [AW-1:0]  buf_addr,
  output logic [SZW-1:0] buf_size,
  input  logic           buf_done,
  input  logic           frame_end,
  output logic           rx_done,
  output logic           size_err
);
  localparam int S2LO = 16;
  localparam logic [AW-1:0] STRIDE = AW'(16);

  typedef enum logic [2:0] {IDLE, FETCH, BUF1, BUF2, HALT} st_t;
  st_t st;

  logic [AW-1:0]  cur, nxt, a1, a2;
  logic [SZW-1:0] s1, s2;
  logic           dic, use2;

  wire [SZW-1:0] in_s1   = rd_ctrl[SZW-1:0];
  wire [SZW-1:0] in_s2   = rd_ctrl[S2LO+SZW-1:S2LO];
  wire           in_eor  = rd_ctrl[15];
  wire           in_chn  = rd_ctrl[14] & ~in_eor;
  wire           in_use2 = ~in_chn & (in_s2 != '0);
  wire           in_bad  = (in_s1[1:0] != 2'b00) | (in_use2 & (in_s2[1:0] != 2'b00));
  wire [AW-1:0]  in_nxt  = in_eor ? base_addr : in_chn ? rd_buf2 : cur + STRIDE;
  wire           release_buf = buf_done | frame_end;

  always_ff @(posedge clk) begin
    if (rst) begin
      st   <= IDLE;
      cur  <= base_addr;
      nxt  <= '0;
      a1   <= '0;
      a2   <= '0;
      s1   <= '0;
      s2   <= '0;
      dic  <= 1'b0;
      use2 <= 1'b0;
    end else begin
      case (st)
        IDLE: if (run) st <= FETCH;
        FETCH: if (rd_valid) begin
          a1   <= rd_buf1;
          a2   <= rd_buf2;
          s1   <= in_s1;
          s2   <= in_s2;
          dic  <= rd_ctrl[31];
          use2 <= in_use2;
          nxt  <= in_nxt;
          if (in_bad)             st <= HALT;
          else if (in_s1 != '0)   st <= BUF1;
          else if (in_use2)       st <= BUF2;
          else begin
            cur <= in_nxt;
            st  <= IDLE;
          end
        end
        BUF1: if (release_buf) begin
          if (use2) st <= BUF2;
          else begin
            cur <= nxt;
            st  <= IDLE;
          end
        end
        BUF2: if (release_buf) begin
          cur <= nxt;
          st  <= IDLE;
        end
        default: st <= HALT;
      endcase
    end
  end

  assign rd_req    = (st == FETCH);
  assign rd_addr   = cur;
  assign buf_valid = (st == BUF1) | (st == BUF2);
  assign buf_sel   = (st == BUF2);
  assign buf_addr  = buf_sel ? a2 : a1;
  assign buf_size  = buf_sel ? s2 : s1;
  assign rx_done   = buf_valid & frame_end & ~dic;
  assign size_err  = (st == HALT);

  a_r2_hold_fetch: assert property (@(posedge clk) disable iff (rst)
    (rd_req && !rd_valid) |=> (rd_req && $stable(rd_addr)));

  a_r3_hold_buf: assert property (@(posedge clk) disable iff (rst)
    (buf_valid && !buf_done && !frame_end) |=>
      (buf_valid && $stable(buf_addr) && $stable(buf_size) && $stable(buf_sel)));

  a_r6_ring_step: assert property (@(posedge clk) disable iff (rst)
    (rd_req && rd_valid && !rd_ctrl[15] && !rd_ctrl[14] &&
     rd_ctrl[12:0] == '0 && rd_ctrl[28:16] == '0) |=> (rd_addr == $past(rd_addr) + 32'd16));

  a_r7_chain_ptr: assert property (@(posedge clk) disable iff (rst)
    (rd_req && rd_valid && !rd_ctrl[15] && rd_ctrl[14] && rd_ctrl[12:0] == '0)
      |=> (rd_addr == $past(rd_buf2) && !buf_valid));

  a_r8_ring_end: assert property (@(posedge clk) disable iff (rst)
    (rd_req && rd_valid && rd_ctrl[15] && rd_ctrl[12:0] == '0 && rd_ctrl[28:16] == '0)
      |=> (rd_addr == $past(base_addr)));

  a_r4_skip_first: assert property (@(posedge clk) disable iff (rst)
    (rd_req && rd_valid && rd_ctrl[12:0] == '0 && !(rd_ctrl[14] && !rd_ctrl[15]) &&
     rd_ctrl[28:16] != '0 && rd_ctrl[17:16] == 2'b00) |=> (buf_valid && buf_sel));

  a_r10_misaligned: assert property (@(posedge clk) disable iff (rst)
    (rd_req && rd_valid && rd_ctrl[1:0] != 2'b00) |=> (size_err && !buf_valid));

  a_r10_stay_halted: assert property (@(posedge clk) disable iff (rst)
    size_err |=> (size_err && !rd_req));
endmodule

// File: tb/rx_desc_walker_test.sv
module rx_desc_walker_test;
  logic        clk = 0, rst = 1, run = 0;
  logic [31:0] base_addr = 32'h1000;
  logic        rd_valid = 0, buf_done = 0, frame_end = 0;
  logic [31:0] rd_ctrl = 0, rd_buf1 = 0, rd_buf2 = 0;
  logic        rd_req, buf_valid, buf_sel, rx_done, size_err;
  logic [31:0] rd_addr, buf_addr;
  logic [12:0] buf_size;
  int n_chk = 0, n_bad = 0;

  always #5 clk = ~clk;

  rx_desc_walker uut (.clk(clk), .rst(rst), .base_addr(base_addr), .run(run),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_valid(rd_valid), .rd_ctrl(rd_ctrl),
    .rd_buf1(rd_buf1), .rd_buf2(rd_buf2), .buf_valid(buf_valid), .buf_sel(buf_sel),
    .buf_addr(buf_addr), .buf_size(buf_size), .buf_done(buf_done),
    .frame_end(frame_end), .rx_done(rx_done), .size_err(size_err));

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input bit dic, input bit eor, input bit chn,
                                     input int s1, input int s2);
    return {dic, 2'b00, 13'(s2), eor, chn, 1'b0, 13'(s1)};
  endfunction

  task automatic fetch(input logic [31:0] exp_addr, input logic [31:0] c,
                       input logic [31:0] b1, input logic [31:0] b2, input int dly);
    int i = 0;
    bit stray = 0;
    @(negedge clk);
    while (!rd_req && i < 50) begin
      if (buf_valid) stray = 1;
      @(negedge clk);
      i++;
    end
    chk(!stray, "R5 no buffer before fetch", 32'(stray), 0);
    chk(rd_req, "R2 fetch issued", 32'(rd_req), 1);
    chk(rd_addr == exp_addr, "R6/R7/R8 fetch address", rd_addr, exp_addr);
    for (int k = 0; k < dly; k++) begin
      @(negedge clk);
      chk(rd_req && rd_addr == exp_addr, "R2 request held", rd_addr, exp_addr);
    end
    rd_ctrl = c; rd_buf1 = b1; rd_buf2 = b2; rd_valid = 1;
    @(posedge clk); #1 rd_valid = 0;
  endtask

  task automatic take_buf(input bit sel, input logic [31:0] a, input int sz,
                          input bit fe, input bit exp_done);
    @(negedge clk);
    chk(buf_valid, "R3 buffer request", 32'(buf_valid), 1);
    chk(buf_sel == sel, "R3/R4 buffer order", 32'(buf_sel), 32'(sel));
    chk(buf_addr == a, "R3 buffer address", buf_addr, a);
    chk(buf_size == 13'(sz), "R3/R11 buffer size", 32'(buf_size), 32'(sz));
    if (fe) frame_end = 1; else buf_done = 1;
    #1 chk(rx_done == exp_done, "R9 receive status", 32'(rx_done), 32'(exp_done));
    @(posedge clk); #1 frame_end = 0; buf_done = 0;
  endtask

  task automatic t_reset;
    rst = 1; run = 0;
    repeat (3) @(posedge clk);
    #1 rst = 0;
    @(negedge clk);
    chk(!rd_req && !buf_valid && !size_err, "R1 idle after reset",
        {29'd0, rd_req, buf_valid, size_err}, 0);
    chk(rd_addr == base_addr, "R1 pointer at base", rd_addr, base_addr);
    run = 1;
  endtask

  task automatic t_two_bufs;
    fetch(32'h1000, mk(0,0,0,64,32) | 32'h6000_2000, 32'h2000, 32'h3000, 3);
    take_buf(0, 32'h2000, 64, 0, 0);
    take_buf(1, 32'h3000, 32, 1, 1);
  endtask

  task automatic t_skip_first_dic;
    fetch(32'h1010, mk(1,0,0,0,16), 32'h2100, 32'h3100, 0);
    take_buf(1, 32'h3100, 16, 1, 0);
  endtask

  task automatic t_both_zero;
    fetch(32'h1020, mk(0,0,0,0,0), 32'h2200, 32'h3200, 0);
  endtask

  task automatic t_chain;
    fetch(32'h1030, mk(0,0,1,8,5), 32'h2300, 32'h4000, 1);
    take_buf(0, 32'h2300, 8, 1, 1);
  endtask

  task automatic t_eor_over_chain;
    fetch(32'h4000, mk(0,1,1,4,12), 32'h2400, 32'h5000, 0);
    take_buf(0, 32'h2400, 4, 0, 0);
    take_buf(1, 32'h5000, 12, 0, 0);
  endtask

  task automatic t_misaligned;
    bit seen = 0;
    fetch(32'h1000, mk(0,0,0,6,0), 32'h2500, 32'h3500, 0);
    @(negedge clk);
    chk(size_err, "R10 error flagged", 32'(size_err), 1);
    for (int k = 0; k < 20; k++) begin
      if (rd_req || buf_valid) seen = 1;
      @(negedge clk);
    end
    chk(!seen, "R10 halted", 32'(seen), 0);
    chk(size_err, "R10 error held", 32'(size_err), 1);
  endtask

  initial begin
    fork
      begin
        t_reset;
        t_two_bufs;
        t_skip_first_dic;
        t_both_zero;
        t_chain;
        t_eor_over_chain;
        t_misaligned;
        t_reset;
        fetch(32'h1000, mk(0,0,0,0,4), 32'h0, 32'h3600, 0);
        take_buf(1, 32'h3600, 4, 1, 1);
      end
      begin
        repeat (5000) @(posedge clk);
        chk(0, "watchdog expired", 0, 1);
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule